// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip: a serial controller clocked by a dedicated test clock that walks the sixteen-state control machine under a mode-select input, and moves bits between a serial data input and a serial data output. A 3-bit instruction register picks which data register sits between the two serial pins. The choices are a one-bit bypass stage, a fixed 32-bit identification word, and a boundary chain whose length is a parameter.

The instruction map is sparse. Three codes route the boundary chain: external test, sample, and a scan-test code reserved for production test. One code selects the identification word, and the other four all select bypass. The block drives the decoded mode flags and the boundary update outputs to the rest of the chip. The serial output is launched on the falling test-clock edge and is enabled only while a shift state is active. An active-low reset input returns the controller to its reset state asynchronously, and that reset is released synchronously to the test clock.

Top module: `scan_port_ctrl`

## Requirements
- R1: The control machine has sixteen states. It moves on each rising edge of `tck` according to `tms`, following the standard test-port state graph, including the pause loops inside the data and instruction paths.
- R2: While `trst_n` is low, the following hold at once, without waiting for a clock edge: the controller is in its reset state, the held instruction is 001 (identification), `tdo_oe` is 0, and `bsr_upd` equals `UPD_RESET` (all ones by default, so every control cell reads 1 and every tri-state output is disabled). After release, the controller leaves the reset state no earlier than the third rising edge of `tck`.
- R3: Five consecutive rising edges of `tck` with `tms` high reach the reset state from any state, and the held instruction becomes 001.
- R4: Capture-IR loads 001 into the instruction shift stage. Instruction bits shift least significant bit first.
- R5: Instruction decode works as follows. 000 raises `mode_extest` and selects the boundary chain. 010 raises `mode_sample` and selects the boundary chain. 101 raises `mode_scantest` and selects the boundary chain. 001 selects the identification word. 011, 100, 110 and 111 select bypass. No mode flag is raised for 001 or for any bypass code.
- R6: With 001 held, a data scan returns 32'h173640CD, least significant bit first. This value is version 0001, part field 7364 hex, maker field 00001100110, and a final 1.
- R7: The bypass stage captures 0 and delays `tdi` by exactly one shift.
- R8: When the boundary chain is selected, Capture-DR loads `bsr_in`. Cell 0 is the first bit out on `tdo`, and `tdi` enters at cell `BSR_LEN-1`.
- R9: Update-DR copies the boundary shift chain to `bsr_upd` on the falling edge of `tck`, and only when the boundary chain is selected. `bsr_upd` does not change during a data shift or during a bypass or identification scan.
- R10: `tdo` changes on the falling edge of `tck`. `tdo_oe` is 1 only while Shift-IR or Shift-DR is active.
- R11: Update-IR copies the instruction shift stage to the held instruction on the falling edge of `tck`. The mode flags do not change during an instruction shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, launched on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bsr_in | input | BSR_LEN | Values captured into the boundary chain |
| bsr_upd | output | BSR_LEN | Boundary update outputs |
| mode_extest | output | 1 | External-test instruction held |
| mode_sample | output | 1 | Sample instruction held |
| mode_scantest | output | 1 | Scan-test instruction held |

## Verification
A wrong control state shows up within one falling edge: `tdo_oe` rises or falls out of step with the shift window, or the first bit of a scan comes from the wrong register. A wrong decode shows up only at the next data scan, as the wrong length or content: the 32-bit identification word, a one-shift delay, or the captured `bsr_in` pattern. A faulty update path shows up at `bsr_upd` right after the falling edge in Update-DR, or as movement of `bsr_upd` during a shift. Reset faults show up directly after `trst_n` falls, or after five `tms`-high clocks, as non-zero mode flags or a `bsr_upd` that is not all ones.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EX1_DR, ST_PAUSE_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EX1_IR, ST_PAUSE_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    DR_BYPASS, DR_IDENT, DR_BOUND
  } dr_sel_e;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST   = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT    = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 3'b010;
  localparam logic [IR_W-1:0] OP_SCANTEST = 3'b101;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;

  localparam logic [3:0]  ID_VERSION = 4'b0001;
  localparam logic [15:0] ID_PART    = 16'h7364;
  localparam logic [10:0] ID_MAKER   = 11'b00001100110;
  localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

endpackage

// File: rtl/scan_port_fsm.sv
module scan_port_fsm
  import scan_port_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     state_d = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   state_d = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   state_d = tms ? ST_EX1_DR   : ST_SHIFT_DR;
      ST_SHIFT_DR: state_d = tms ? ST_EX1_DR   : ST_SHIFT_DR;
      ST_EX1_DR:   state_d = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: state_d = tms ? ST_EX2_DR   : ST_PAUSE_DR;
      ST_EX2_DR:   state_d = tms ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   state_d = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   state_d = tms ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   state_d = tms ? ST_EX1_IR   : ST_SHIFT_IR;
      ST_SHIFT_IR: state_d = tms ? ST_EX1_IR   : ST_SHIFT_IR;
      ST_EX1_IR:   state_d = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: state_d = tms ? ST_EX2_IR   : ST_PAUSE_IR;
      ST_EX2_IR:   state_d = tms ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   state_d = tms ? ST_SEL_DR   : ST_IDLE;
      default:     state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_d;
  end

endmodule

// File: rtl/scan_port_ir.sv
module scan_port_ir
  import scan_port_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic            ir_lsb,
  output logic [IR_W-1:0] ir_hold
);

  logic [IR_W-1:0] ir_sr, ir_sr_d;
  logic            sr_en, hold_en;
  logic [IR_W-1:0] hold_d;

  always_comb begin
    sr_en   = 1'b0;
    ir_sr_d = ir_sr;
    if (state == ST_CAP_IR) begin
      sr_en   = 1'b1;
      ir_sr_d = IR_CAPTURE;
    end else if (state == ST_SHIFT_IR) begin
      sr_en   = 1'b1;
      ir_sr_d = {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_sr <= IR_CAPTURE;
    else if (sr_en) ir_sr <= ir_sr_d;
  end

  always_comb begin
    hold_en = (state == ST_RESET) || (state == ST_UPD_IR);
    hold_d  = (state == ST_RESET) ? OP_IDENT : ir_sr;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)       ir_hold <= OP_IDENT;
    else if (hold_en) ir_hold <= hold_d;
  end

  assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/scan_port_dr.sv
module scan_port_dr
  import scan_port_pkg::*;
#(
  parameter int                 BSR_LEN   = 268,
  parameter logic [BSR_LEN-1:0] UPD_RESET = '1
) (
  input  logic               tck,
  input  logic               rst_n,
  input  tap_state_e         state,
  input  dr_sel_e            sel,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] bsr_in,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] bsr_upd
);

  logic               cap, shf;
  logic               byp_q, byp_d, byp_en;
  logic [ID_W-1:0]    id_q, id_d;
  logic               id_en;
  logic [BSR_LEN-1:0] bs_q, bs_d;
  logic               bs_en, upd_en;

  assign cap = (state == ST_CAP_DR);
  assign shf = (state == ST_SHIFT_DR);

  always_comb begin
    byp_en = (sel == DR_BYPASS) && (cap || shf);
    byp_d  = cap ? 1'b0 : tdi;
    id_en  = (sel == DR_IDENT) && (cap || shf);
    id_d   = cap ? ID_WORD : {tdi, id_q[ID_W-1:1]};
    bs_en  = (sel == DR_BOUND) && (cap || shf);
    bs_d   = cap ? bsr_in : {tdi, bs_q[BSR_LEN-1:1]};
    upd_en = (sel == DR_BOUND) && (state == ST_UPD_DR);
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     id_q <= ID_WORD;
    else if (id_en) id_q <= id_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     bs_q <= UPD_RESET;
    else if (bs_en) bs_q <= bs_d;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      bsr_upd <= UPD_RESET;
    else if (upd_en) bsr_upd <= bs_q;
  end

  always_comb begin
    case (sel)
      DR_IDENT: dr_lsb = id_q[0];
      DR_BOUND: dr_lsb = bs_q[0];
      default:  dr_lsb = byp_q;
    endcase
  end

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_port_pkg::*;
#(
  parameter int                 BSR_LEN   = 268,
  parameter logic [BSR_LEN-1:0] UPD_RESET = '1
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] bsr_in,
  output logic [BSR_LEN-1:0] bsr_upd,
  output logic               mode_extest,
  output logic               mode_sample,
  output logic               mode_scantest
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n;
  tap_state_e             state;
  logic                   ir_lsb, dr_lsb;
  logic [IR_W-1:0]        ir_hold;
  dr_sel_e                dr_sel;
  logic                   tdo_d, oe_d;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_pipe[SYNC_STAGES-1];

  scan_port_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  scan_port_ir u_ir (
    .tck     (tck),
    .rst_n   (rst_n),
    .state   (state),
    .tdi     (tdi),
    .ir_lsb  (ir_lsb),
    .ir_hold (ir_hold)
  );

  always_comb begin
    mode_extest   = (ir_hold == OP_EXTEST);
    mode_sample   = (ir_hold == OP_SAMPLE);
    mode_scantest = (ir_hold == OP_SCANTEST);
    if (mode_extest || mode_sample || mode_scantest) dr_sel = DR_BOUND;
    else if (ir_hold == OP_IDENT)                    dr_sel = DR_IDENT;
    else                                             dr_sel = DR_BYPASS;
  end

  scan_port_dr #(
    .BSR_LEN   (BSR_LEN),
    .UPD_RESET (UPD_RESET)
  ) u_dr (
    .tck     (tck),
    .rst_n   (rst_n),
    .state   (state),
    .sel     (dr_sel),
    .tdi     (tdi),
    .bsr_in  (bsr_in),
    .dr_lsb  (dr_lsb),
    .bsr_upd (bsr_upd)
  );

  always_comb begin
    oe_d  = (state == ST_SHIFT_IR) || (state == ST_SHIFT_DR);
    tdo_d = (state == ST_SHIFT_IR) ? ir_lsb : dr_lsb;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= oe_d;
    end
  end

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_port_pkg::*;
#(
  parameter int BSR_LEN = 268
) (
  input logic               tck,
  input logic               rst_n,
  input logic               tms,
  input tap_state_e         state,
  input logic               tdo_oe,
  input logic [IR_W-1:0]    ir_hold,
  input logic [BSR_LEN-1:0] bsr_upd
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                 ones_cnt <= '0;
    else if (!tms)              ones_cnt <= '0;
    else if (ones_cnt != 3'd5)  ones_cnt <= ones_cnt + 3'd1;
  end

  // R10: enable launched on the falling edge tracks the shift states
  a_r10_oe_in_shift: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == ((state == ST_SHIFT_IR) || (state == ST_SHIFT_DR)));

  // R9: update outputs hold through a data shift
  a_r9_upd_stable_shift: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_SHIFT_DR) |=> $stable(bsr_upd));

  // R11: held instruction holds through an instruction shift
  a_r11_ir_stable_shift: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_SHIFT_IR) |=> $stable(ir_hold));

  // R3: reset state reloads the identification instruction
  a_r3_reset_loads_ident: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |=> (ir_hold == OP_IDENT));

  // R3: five tms-high edges reach the reset state
  a_r3_five_ones: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_cnt == 3'd5) |-> (state == ST_RESET));

endmodule

bind scan_port_ctrl scan_port_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck     (tck),
  .rst_n   (rst_n),
  .tms     (tms),
  .state   (state),
  .tdo_oe  (tdo_oe),
  .ir_hold (ir_hold),
  .bsr_upd (bsr_upd)
);

// File: tb/scan_port_ctrl_test.sv
module scan_port_ctrl_test;

  localparam int TCK_PERIOD = 20;
  localparam int BSR_LEN    = 268;
  localparam logic [31:0] EXP_ID = 32'h173640CD;

  logic               tck, trst_n, tms, tdi;
  logic               tdo, tdo_oe;
  logic [BSR_LEN-1:0] bsr_in, bsr_upd;
  logic               mode_extest, mode_sample, mode_scantest;

  int checks = 0;
  int errors = 0;

  scan_port_ctrl #(.BSR_LEN(BSR_LEN)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .bsr_in(bsr_in), .bsr_upd(bsr_upd), .mode_extest(mode_extest),
    .mode_sample(mode_sample), .mode_scantest(mode_scantest)
  );

  initial tck = 1'b0;
  always #(TCK_PERIOD/2) tck = ~tck;

  task automatic check(input bit ok, input string req, input logic [BSR_LEN-1:0] act,
                       input logic [BSR_LEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    tms = m;
    tdi = d;
    o   = tdo;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic idle_steps(input int n);
    logic o;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, o);
  endtask

  // from Run-Test/Idle back to Run-Test/Idle
  task automatic scan_ir(input logic [2:0] din, output logic [2:0] dout, output bit mode_moved);
    logic o;
    logic [2:0] m0;
    m0 = {mode_extest, mode_sample, mode_scantest};
    mode_moved = 0;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 3; i++) begin
      if (!tdo_oe) mode_moved = 1;
      step(i == 2, din[i], o);
      dout[i] = o;
      if ({mode_extest, mode_sample, mode_scantest} != m0) mode_moved = 1;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic scan_dr(input int n, input logic [BSR_LEN-1:0] din,
                         output logic [BSR_LEN-1:0] dout, output bit upd_moved, output bit oe_bad);
    logic o;
    logic [BSR_LEN-1:0] u0;
    dout = '0;
    upd_moved = 0;
    oe_bad = 0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    u0 = bsr_upd;
    for (int i = 0; i < n; i++) begin
      if (!tdo_oe) oe_bad = 1;
      step(i == n-1, din[i], o);
      dout[i] = o;
      if (bsr_upd != u0) upd_moved = 1;
    end
    if (tdo_oe) oe_bad = 1;
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic do_reset();
    logic o;
    trst_n = 1'b0;
    tms = 1'b1;
    #3;
    check(tdo_oe == 0, "R2 oe low in reset", BSR_LEN'(tdo_oe), '0);
    check(bsr_upd == '1, "R2 update outputs safe", bsr_upd, '1);
    check({mode_extest, mode_sample, mode_scantest} == 3'b000, "R2 modes clear",
          BSR_LEN'({mode_extest, mode_sample, mode_scantest}), '0);
    @(negedge tck); #1;
    trst_n = 1'b1;
    step(1, 0, o); step(1, 0, o); step(1, 0, o);
    step(0, 0, o);
  endtask

  task automatic test_reset_ident();
    logic [BSR_LEN-1:0] d;
    bit um, ob;
    do_reset();
    scan_dr(32, '0, d, um, ob);
    check(d[31:0] == EXP_ID, "R6 ident after reset", BSR_LEN'(d[31:0]), BSR_LEN'(EXP_ID));
    check(!ob, "R10 oe only in shift", BSR_LEN'(ob), '0);
    check(!um && bsr_upd == '1, "R9 ident scan leaves updates", bsr_upd, '1);
  endtask

  task automatic test_ir_capture();
    logic [2:0] q;
    bit mm;
    scan_ir(3'b001, q, mm);
    check(q == 3'b001, "R4 capture pattern", BSR_LEN'(q), BSR_LEN'(3'b001));
  endtask

  task automatic test_bypass(input logic [2:0] op);
    logic [2:0] q;
    logic [BSR_LEN-1:0] din, d, exp;
    bit mm, um, ob;
    scan_ir(op, q, mm);
    check({mode_extest, mode_sample, mode_scantest} == 3'b000, "R5 bypass no mode",
          BSR_LEN'({mode_extest, mode_sample, mode_scantest}), '0);
    din = '0;
    din[7:0] = 8'hB5 ^ {5'b0, op};
    scan_dr(8, din, d, um, ob);
    exp = '0;
    exp[7:0] = {din[6:0], 1'b0};
    check(d[7:0] == exp[7:0], "R7 bypass one-shift delay", d & BSR_LEN'(8'hFF), exp);
    check(bsr_upd == '1, "R9 bypass ignores update", bsr_upd, '1);
  endtask

  task automatic test_boundary(input logic [2:0] op, input string tag);
    logic [2:0] q;
    logic [BSR_LEN-1:0] din, d;
    bit mm, um, ob;
    for (int i = 0; i < BSR_LEN; i++) begin
      bsr_in[i] = ((i * 7 + op) % 5) < 2;
      din[i]    = ((i * 3 + op) % 4) == 1;
    end
    scan_ir(op, q, mm);
    check(mode_extest == (op == 3'b000) && mode_sample == (op == 3'b010) &&
          mode_scantest == (op == 3'b101), {tag, " R5 mode flag"},
          BSR_LEN'({mode_extest, mode_sample, mode_scantest}), BSR_LEN'(op));
    scan_dr(BSR_LEN, din, d, um, ob);
    check(d == bsr_in, {tag, " R8 capture order"}, d, bsr_in);
    check(!um, {tag, " R9 stable during shift"}, BSR_LEN'(um), '0);
    check(bsr_upd == din, {tag, " R9 update value"}, bsr_upd, din);
  endtask

  task automatic test_ir_hold();
    logic [2:0] q;
    bit mm;
    scan_ir(3'b000, q, mm);
    scan_ir(3'b010, q, mm);
    check(!mm, "R11 modes stable during ir shift", BSR_LEN'(mm), '0);
    check(mode_sample && !mode_extest, "R11 new instruction after update",
          BSR_LEN'({mode_extest, mode_sample}), BSR_LEN'(2'b01));
  endtask

  task automatic test_pause_ident();
    logic o;
    logic [2:0] q;
    logic [31:0] d;
    bit mm;
    scan_ir(3'b001, q, mm);
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 16; i++) begin step(i == 15, 0, o); d[i] = o; end
    step(0, 0, o); step(0, 0, o); step(0, 0, o);
    check(tdo_oe == 0, "R1 oe low in pause", BSR_LEN'(tdo_oe), '0);
    step(1, 0, o); step(0, 0, o);
    for (int i = 16; i < 32; i++) begin step(i == 31, 0, o); d[i] = o; end
    step(1, 0, o); step(0, 0, o);
    check(d == EXP_ID, "R1 ident across pause", BSR_LEN'(d), BSR_LEN'(EXP_ID));
  endtask

  task automatic test_five_ones();
    logic o;
    logic [2:0] q;
    logic [BSR_LEN-1:0] d;
    bit mm, um, ob;
    scan_ir(3'b000, q, mm);
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 5; i++) step(1, 1, o);
    step(0, 0, o);
    check({mode_extest, mode_sample, mode_scantest} == 3'b000, "R3 five ones clears mode",
          BSR_LEN'({mode_extest, mode_sample, mode_scantest}), '0);
    scan_dr(32, '0, d, um, ob);
    check(d[31:0] == EXP_ID, "R3 ident selected again", BSR_LEN'(d[31:0]), BSR_LEN'(EXP_ID));
  endtask

  task automatic test_async_trst();
    logic o;
    logic [2:0] q;
    bit mm;
    scan_ir(3'b010, q, mm);
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    step(0, 1, o); step(0, 0, o);
    trst_n = 1'b0;
    #2;
    check(tdo_oe == 0 && mode_sample == 0, "R2 async reset mid-shift",
          BSR_LEN'({tdo_oe, mode_sample}), '0);
    do_reset();
  endtask

  task automatic test_tdo_edge();
    logic [2:0] q;
    logic o;
    bit mm;
    scan_ir(3'b001, q, mm);
    step(1, 0, o); step(0, 0, o);
    tms = 0;
    @(posedge tck); #2;
    check(tdo_oe == 0, "R10 oe waits for falling edge", BSR_LEN'(tdo_oe), '0);
    @(negedge tck); #1;
    check(tdo_oe == 1 && tdo == EXP_ID[0], "R10 first bit on falling edge",
          BSR_LEN'({tdo_oe, tdo}), BSR_LEN'(2'b11));
    do_reset();
  endtask

  initial begin
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; bsr_in = '0;
    #(TCK_PERIOD * 2);
    test_reset_ident();
    test_ir_capture();
    test_bypass(3'b011);
    test_bypass(3'b100);
    test_bypass(3'b110);
    test_bypass(3'b111);
    test_boundary(3'b010, "sample");
    test_boundary(3'b000, "extest");
    test_boundary(3'b101, "scantest");
    test_ir_hold();
    test_pause_ident();
    test_five_ones();
    test_async_trst();
    test_tdo_edge();
    idle_steps(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(TCK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule